// File: doc/BRIEF.md
# Byte-Wide Host Register Interface

This block is the host-facing register file of a sampling converter. A host reaches it over a parallel bus. The bus has active-low chip select, read and write strobes, a byte-select line and a 12-bit data bus. All of these are sampled on the block clock. Every write is a 16-bit word sent as two byte transfers. The upper two bits of that word pick the destination register, and the remaining 14 bits are its payload. There is no address bus.

Reads return whichever source the read-select field of the control register points at. That field keeps its value until the next control write. A 12-bit value can be read in one transfer with the byte-select low. The upper byte is read with the byte-select high.

The calibration bank holds ten coefficient registers. An internal pointer walks through them in an order set by the calibration-select field. The pointer moves forward after each completed coefficient write, and after each complete low-then-high read pair. The conversion and calibration engines sit outside this block. The block gives them request bits and field values, and takes back their result, status and completion pulses.

Top module: `hbi_regs`

## Requirements
- R1: After reset, all control outputs are 0, the write sequence expects a low byte, and a read returns the conversion result (read-select 00).
- R2: `db_oe` is 1 only while `cs_n` and `rd_n` are both low. While `db_oe` is 0, `db_out` is all zeros.
- R3: A word is formed from two write strobes (a rising `wr_n` with `cs_n` low). The first strobe carries word bits 7:0 on `db_in[7:0]`, and the second carries bits 15:8.
- R4: A word whose bits 15:14 are 00 changes no register. A write strobe while `cs_n` is high is ignored and does not advance the byte sequence.
- R5: Read-select 00 returns the conversion result, 01 the test register, 10 the calibration entry at the pointer, and 11 the status word. A read with `hben` low gives bits 11:0 of the source. A read with `hben` high gives bits 15:8 on `db_out[7:0]`, with `db_out[11:8]` at zero. The read-select field changes only on a control write.
- R6: Word bits 15:14 = 01 load bits 13:0 into a 14-bit test register, which can be read back.
- R7: Control bit 4 raises `conv_req`, which stays high until a `conv_done` pulse. Control bit 0 raises `cal_req`, which stays high until a `cal_done` pulse.
- R8: The calibration entries are indexed 0 = gain, 1 = offset and 2..9 = DAC coefficients. The walk order depends on calibration-select:
  - 00 walks 0..9;
  - 01 walks 0, 1;
  - 10 stays at 1;
  - 11 stays at 0.
  The walk wraps to its first entry, and every control write restarts it there.
- R9: Word bits 15:14 = 10 write the entry at the pointer, but only while control bit 0 is 0. Otherwise the write is ignored.
- R10: The calibration pointer advances on a high-byte read only when a low-byte read of the same entry came before it. A repeated high-byte read does not advance it.
- R11: The control word carries power mode in bits 9:8, read-select in 7:6, range in 5, conversion start in 4, calibration kind in 3, calibration-select in 2:1 and calibration start in 0. Bits 13:10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data taken on its rising edge |
| hben | input | 1 | Byte select for reads (1 = upper byte) |
| db_in | input | 12 | Host data into the block (bits 7:0 used for writes) |
| db_out | output | 12 | Read data toward the host |
| db_oe | output | 1 | Output enable for the data bus |
| adc_word | input | 12 | Latest conversion result |
| stat_word | input | 16 | Status word from the engines |
| conv_done | input | 1 | Pulse: conversion finished |
| cal_done | input | 1 | Pulse: calibration finished |
| pwr_mode | output | 2 | Power mode field |
| range_bipolar | output | 1 | Input range select |
| conv_req | output | 1 | Conversion request |
| cal_system | output | 1 | Calibration kind (0 self, 1 system) |
| cal_sel | output | 2 | Calibration-select field |
| cal_req | output | 1 | Calibration request |

## Verification
A stuck or skipped byte-sequence bit shows up on the very next word. It sends the payload to the wrong register or to none, so the mode outputs or a read-back disagree within a few bus cycles. A pointer that starts, steps or wraps wrongly shows up as a coefficient out of order on the next read pair. The sweeps therefore read each bank order twice around its wrap. A sticky field that changes by itself, or a request bit that clears without its done pulse, is visible on the mode outputs or on the next read.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int BUS_W  = 12;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int REG_W  = WORD_W - 2;
    localparam int CAL_N  = 10;
    localparam int PTR_W  = 4;

    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_TEST = 2'b01,
        DST_CAL  = 2'b10,
        DST_CTRL = 2'b11
    } wdst_e;

    typedef enum logic [1:0] {
        SRC_ADC  = 2'b00,
        SRC_TEST = 2'b01,
        SRC_CAL  = 2'b10,
        SRC_STAT = 2'b11
    } rsrc_e;

    typedef struct packed {
        wdst_e             dst;
        logic [REG_W-1:0]  body;
    } hword_t;

    typedef struct packed {
        logic [1:0] pmgt;
        rsrc_e      rdsel;
        logic       bipolar;
        logic       conv;
        logic       sys_cal;
        logic [1:0] calsel;
        logic       cal_go;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // first entry of the walk for a calibration-select value
    function automatic logic [PTR_W-1:0] cal_first(input logic [1:0] s);
        return (s == 2'b10) ? PTR_W'(1) : PTR_W'(0);
    endfunction

    // last entry of the walk for a calibration-select value
    function automatic logic [PTR_W-1:0] cal_last(input logic [1:0] s);
        case (s)
            2'b00:   return PTR_W'(CAL_N - 1);
            2'b01:   return PTR_W'(1);
            2'b10:   return PTR_W'(1);
            default: return PTR_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/hbi_strobe.sv
module hbi_strobe #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hben,
    input  logic [BYTE_W-1:0] db_lo,
    output logic              wr_evt,
    output logic              rd_evt,
    output logic              rd_hi,
    output logic [BYTE_W-1:0] wr_byte
);
    logic              q_cs_n, q_wr_n, q_rd_n, q_hben;
    logic [BYTE_W-1:0] q_db;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_cs_n <= 1'b1;
            q_wr_n <= 1'b1;
            q_rd_n <= 1'b1;
            q_hben <= 1'b0;
            q_db   <= '0;
        end else begin
            q_cs_n <= cs_n;
            q_wr_n <= wr_n;
            q_rd_n <= rd_n;
            q_hben <= hben;
            q_db   <= db_lo;
        end
    end

    // a strobe completes when it was low with chip select and is now high
    assign wr_evt  = !rst && !q_cs_n && !q_wr_n && wr_n;
    assign rd_evt  = !rst && !q_cs_n && !q_rd_n && rd_n;
    assign rd_hi   = q_hben;
    assign wr_byte = q_db;

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !wr_evt);
endmodule

// File: rtl/hbi_wr_pack.sv
module hbi_wr_pack
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              word_evt,
    output hword_t            word
);
    logic              hi_phase;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_phase <= 1'b0;
            lo_q     <= '0;
        end else if (wr_evt) begin
            hi_phase <= !hi_phase;
            if (!hi_phase) lo_q <= wr_byte;
        end
    end

    assign word_evt = wr_evt && hi_phase;
    assign word     = hword_t'({wr_byte, lo_q});

    // R3
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> (hi_phase != $past(hi_phase)));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_evt |=> $stable(hi_phase));
endmodule

// File: rtl/hbi_cal_bank.sv
module hbi_cal_bank
    import hbi_pkg::*;
#(
    parameter int N = CAL_N,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   sel,
    input  logic [1:0]   reload_sel,
    input  logic         reload,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_lo,
    input  logic         rd_hi,
    output logic [W-1:0] rd_word
);
    localparam int PW = PTR_W;

    logic [PW-1:0] ptr;
    logic          lo_seen;
    logic          step;
    logic [W-1:0]  mem [N];

    assign step = wr_en || (rd_hi && lo_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= cal_first(2'b00);
        end else if (reload) begin
            ptr <= cal_first(reload_sel);
        end else if (step) begin
            ptr <= (ptr == cal_last(sel)) ? cal_first(sel) : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reload) lo_seen <= 1'b0;
        else if (rd_lo)    lo_seen <= 1'b1;
        else if (rd_hi)    lo_seen <= 1'b0;
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                             mem[g] <= '0;
            else if (wr_en && ptr == PW'(g))     mem[g] <= wr_data;
        end
    end

    assign rd_word = (int'(ptr) < N) ? mem[ptr] : '0;

    // R8
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr >= cal_first(sel)) && (ptr <= cal_last(sel)));

    // R10
    ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> $past(wr_en || rd_hi || reload));
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
    import hbi_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              hben,
    input  logic [BUS_W-1:0]  db_in,
    output logic [BUS_W-1:0]  db_out,
    output logic              db_oe,
    input  logic [DATA_W-1:0] adc_word,
    input  logic [STAT_W-1:0] stat_word,
    input  logic              conv_done,
    input  logic              cal_done,
    output logic [1:0]        pwr_mode,
    output logic              range_bipolar,
    output logic              conv_req,
    output logic              cal_system,
    output logic [1:0]        cal_sel,
    output logic              cal_req
);
    logic              wr_evt, rd_evt, rd_hi;
    logic [BYTE_W-1:0] wr_byte;
    logic              word_evt;
    hword_t            word;
    ctrl_t             ctrl_q, ctrl_new;
    logic              ctrl_wr, test_wr, cal_wr, cal_rd;
    logic [REG_W-1:0]  test_q, cal_word;
    logic [WORD_W-1:0] view;

    hbi_strobe #(.BYTE_W(BYTE_W)) u_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .db_lo(db_in[BYTE_W-1:0]),
        .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_hi(rd_hi), .wr_byte(wr_byte)
    );

    hbi_wr_pack u_pack (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_byte(wr_byte),
        .word_evt(word_evt), .word(word)
    );

    assign ctrl_new = ctrl_t'(word.body[CTRL_W-1:0]);
    assign ctrl_wr  = word_evt && (word.dst == DST_CTRL);
    assign test_wr  = word_evt && (word.dst == DST_TEST);
    assign cal_wr   = word_evt && (word.dst == DST_CAL) && !ctrl_q.cal_go;
    assign cal_rd   = rd_evt && (ctrl_q.rdsel == SRC_CAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
        end else begin
            if (conv_done) ctrl_q.conv   <= 1'b0;
            if (cal_done)  ctrl_q.cal_go <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          test_q <= '0;
        else if (test_wr) test_q <= word.body;
    end

    hbi_cal_bank #(.N(CAL_N), .W(REG_W)) u_cal (
        .clk(clk), .rst(rst), .sel(ctrl_q.calsel), .reload_sel(ctrl_new.calsel),
        .reload(ctrl_wr), .wr_en(cal_wr), .wr_data(word.body),
        .rd_lo(cal_rd && !rd_hi), .rd_hi(cal_rd && rd_hi), .rd_word(cal_word)
    );

    always_comb begin
        case (ctrl_q.rdsel)
            SRC_ADC:  view = WORD_W'(adc_word);
            SRC_TEST: view = WORD_W'(test_q);
            SRC_CAL:  view = WORD_W'(cal_word);
            default:  view = WORD_W'(stat_word);
        endcase
    end

    assign db_oe  = !cs_n && !rd_n;
    assign db_out = !db_oe ? '0
                  : hben   ? BUS_W'(view[WORD_W-1:BYTE_W])
                  :          view[BUS_W-1:0];

    assign pwr_mode      = ctrl_q.pmgt;
    assign range_bipolar = ctrl_q.bipolar;
    assign conv_req      = ctrl_q.conv;
    assign cal_system    = ctrl_q.sys_cal;
    assign cal_sel       = ctrl_q.calsel;
    assign cal_req       = ctrl_q.cal_go;

    // R5
    rdsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q.rdsel));

    // R7
    conv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_req) |-> $past(conv_done || ctrl_wr));

    // R7
    cal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cal_req) |-> $past(cal_done || ctrl_wr));

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (db_out == '0));
endmodule

// File: tb/sim_hbi_regs.sv
module sim_hbi_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hben = 1'b0;
    logic [11:0] db_in = '0;
    logic [11:0] db_out;
    logic        db_oe;
    logic [11:0] adc = '0;
    logic [15:0] stat = '0;
    logic        conv_done = 1'b0, cal_done = 1'b0;
    logic [1:0]  pwr_mode, cal_sel;
    logic        range_bipolar, conv_req, cal_system, cal_req;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [13:0] calv [10];

    always #2 clk = !clk;

    hbi_regs u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hben(hben),
        .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .adc_word(adc),
        .stat_word(stat), .conv_done(conv_done), .cal_done(cal_done),
        .pwr_mode(pwr_mode), .range_bipolar(range_bipolar), .conv_req(conv_req),
        .cal_system(cal_system), .cal_sel(cal_sel), .cal_req(cal_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic sel_low);
        @(negedge clk);
        cs_n = !sel_low; db_in = {4'h0, b}; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr_byte(w[7:0], 1'b1);
        wr_byte(w[15:8], 1'b1);
    endtask

    task automatic rd_bus(input logic h, output logic [11:0] v);
        @(negedge clk);
        cs_n = 1'b0; hben = h; rd_n = 1'b0;
        @(negedge clk);
        v = db_out;
        chk("R2 oe during read", {31'd0, db_oe}, 32'd1);
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; hben = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input logic [1:0] pm, input logic [1:0] rs,
                                              input logic am, input logic cv, input logic cm,
                                              input logic [1:0] cs, input logic go);
        return {2'b11, 4'b0000, pm, rs, am, cv, cm, cs, go};
    endfunction

    function automatic logic [3:0] first_of(input logic [1:0] s);
        return (s == 2'b10) ? 4'd1 : 4'd0;
    endfunction

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'b00:   return 10;
            2'b01:   return 2;
            default: return 1;
        endcase
    endfunction

    task automatic rd_cal_pair(input int idx, input string tag);
        logic [11:0] v;
        rd_bus(1'b0, v);
        chk(tag, {20'd0, v}, {20'd0, calv[idx][11:0]});
        rd_bus(1'b1, v);
        chk(tag, {20'd0, v}, {26'd0, calv[idx][13:8]});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwr_mode", {30'd0, pwr_mode}, 0);
        chk("R1 conv_req", {31'd0, conv_req}, 0);
        chk("R1 cal_req", {31'd0, cal_req}, 0);
        chk("R1 cal_sel", {30'd0, cal_sel}, 0);
        chk("R2 oe idle", {31'd0, db_oe}, 0);
        adc = 12'hA5C;
        rd_bus(1'b0, v);
        chk("R1 default read adc", {20'd0, v}, 32'hA5C);

        // R2 strobe combinations that must not drive
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        #1 chk("R2 cs only oe", {31'd0, db_oe}, 0);
        chk("R2 cs only data", {20'd0, db_out}, 0);
        cs_n = 1'b1; rd_n = 1'b0;
        #1 chk("R2 rd only oe", {31'd0, db_oe}, 0);
        chk("R2 rd only data", {20'd0, db_out}, 0);
        rd_n = 1'b1;

        // R11 R3 control field sweep, junk in bits 13:10
        for (int pm = 0; pm < 4; pm++)
            for (int am = 0; am < 2; am++)
                for (int cm = 0; cm < 2; cm++)
                    for (int cs = 0; cs < 4; cs++) begin
                        wr_word(ctrl_word(2'(pm), 2'b00, 1'(am), 1'b0, 1'(cm), 2'(cs), 1'b0) | 16'h3C00);
                        chk("R11 pwr_mode", {30'd0, pwr_mode}, pm);
                        chk("R11 range", {31'd0, range_bipolar}, am);
                        chk("R11 cal kind", {31'd0, cal_system}, cm);
                        chk("R11 cal_sel", {30'd0, cal_sel}, cs);
                    end
        rd_bus(1'b0, v);
        chk("R11 rdsel still adc", {20'd0, v}, 32'hA5C);

        // R4 null address and write with chip select high
        wr_word(ctrl_word(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0));
        wr_word(16'h3FFF);
        chk("R4 null word pm", {30'd0, pwr_mode}, 2);
        chk("R4 null word sel", {30'd0, cal_sel}, 1);
        chk("R4 null word range", {31'd0, range_bipolar}, 1);
        wr_byte(8'hFF, 1'b0);
        wr_word(ctrl_word(2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0));
        chk("R4 cs high ignored pm", {30'd0, pwr_mode}, 1);
        chk("R4 cs high ignored kind", {31'd0, cal_system}, 1);
        chk("R3 byte order sel", {30'd0, cal_sel}, 2);

        // R6 R5 test register sweep
        wr_word(ctrl_word(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
        for (int t = 0; t < 16384; t += 97) begin
            wr_word(16'h4000 | 16'(t));
            rd_bus(1'b0, v);
            chk("R6 test low", {20'd0, v}, t & 32'hFFF);
            rd_bus(1'b1, v);
            chk("R6 test high", {20'd0, v}, t >> 8);
        end

        // R5 status source
        wr_word(ctrl_word(2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
        for (int s = 0; s < 65536; s += 4099) begin
            stat = 16'(s) ^ 16'hA53C;
            rd_bus(1'b0, v);
            chk("R5 status low", {20'd0, v}, {20'd0, stat[11:0]});
            rd_bus(1'b1, v);
            chk("R5 status high", {20'd0, v}, {24'd0, stat[15:8]});
        end

        // R5 conversion result source
        wr_word(ctrl_word(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
        for (int a = 0; a < 4096; a += 273) begin
            adc = 12'(a);
            rd_bus(1'b0, v);
            chk("R5 adc low", {20'd0, v}, a);
            rd_bus(1'b1, v);
            chk("R5 adc high", {20'd0, v}, a >> 8);
        end

        // R8 fill all ten entries through the full walk
        wr_word(ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
        for (int i = 0; i < 10; i++) begin
            calv[i] = 14'((i * 1237 + 55) & 16'h3FFF);
            wr_word(16'h8000 | {2'b00, calv[i]});
        end
        for (logic [2:0] s = 0; s < 4; s++) begin
            wr_word(ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, s[1:0], 1'b0));
            for (int k = 0; k < 2 * len_of(s[1:0]); k++)
                rd_cal_pair(int'(first_of(s[1:0])) + (k % len_of(s[1:0])), "R8 walk");
        end

        // R10 low byte must precede the high byte
        wr_word(ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
        rd_bus(1'b1, v); chk("R10 lone high", {20'd0, v}, {26'd0, calv[0][13:8]});
        rd_bus(1'b1, v); chk("R10 lone high again", {20'd0, v}, {26'd0, calv[0][13:8]});
        rd_cal_pair(0, "R10 first pair");
        rd_bus(1'b0, v); chk("R10 low once", {20'd0, v}, {20'd0, calv[1][11:0]});
        rd_bus(1'b0, v); chk("R10 low twice", {20'd0, v}, {20'd0, calv[1][11:0]});
        rd_bus(1'b1, v); chk("R10 high after lows", {20'd0, v}, {26'd0, calv[1][13:8]});
        rd_bus(1'b0, v); chk("R10 moved once", {20'd0, v}, {20'd0, calv[2][11:0]});

        // R9 coefficient writes blocked while calibration start is set; R7 cal_req
        wr_word(ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1));
        chk("R7 cal_req set", {31'd0, cal_req}, 1);
        wr_word(16'h8000 | 16'h1555);
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        chk("R7 cal_req cleared", {31'd0, cal_req}, 0);
        wr_word(ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0));
        rd_cal_pair(1, "R9 offset unchanged");

        // R7 conversion request
        wr_word(ctrl_word(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0));
        chk("R7 conv_req set", {31'd0, conv_req}, 1);
        repeat (3) @(negedge clk);
        chk("R7 conv_req held", {31'd0, conv_req}, 1);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk("R7 conv_req cleared", {31'd0, conv_req}, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule